// File: doc/BRIEF.md
# Register-Transfer Microoperation Datapath

A small register file joined to one function unit. Each clock, the function unit runs one microoperation. Two multiplexers each pick a register as an operand, and a third source, an external data word, feeds in through a load operation. The result can be written into any set of registers in the same cycle. Each register has its own load enable. A write takes place only when the control condition holds. The control condition is the OR of two control variables.

The unit covers these operations: register transfer, add, a combined add/subtract steered by a mode bit, reverse subtract, one's and two's complement, increment, decrement, bitwise NOT/OR/AND/XOR, and zero-fill shifts by one place. One adder serves every arithmetic operation. Subtraction feeds the adder the inverted operand and forces the carry-in high. Zero and carry status outputs come straight from the current result, so a controller can test them before the clock edge. The operation codes come from outside the block. The block has no sequencing of its own.

Top module: `rt_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero at the next rising clock edge.
- R2: Register i loads the function-unit result at a rising edge only when `dst_en[i]` is 1, `cv_a | cv_b` is 1 and the opcode is defined. Otherwise register i keeps its value.
- R3: `sel_a` and `sel_b` pick any register as operand A and operand B. Opcode 0 transfers A, and every register whose `dst_en` bit is set loads the same value in one cycle. Opcode 13 loads `ext_data`.
- R4: Opcode 1 gives A+B modulo 2^W.
- R5: Opcode 2 gives A+B when `sub_mode`=0, and A+~B+1 (A minus B) when `sub_mode`=1.
- R6: Opcode 3 gives B+~A+1 (B minus A).
- R7: Opcode 4 gives ~A. Opcode 5 gives ~A+1.
- R8: Opcode 6 gives A+1, and all ones wraps to zero. Opcode 7 gives A-1, and zero wraps to all ones.
- R9: Opcodes 8, 9 and 10 give A|B, A&B and A^B. With A=10101010 and B=11110000, these ops and NOT give 11111010, 10100000, 01011010 and 01010101.
- R10: Opcode 11 shifts A left by one place and opcode 12 shifts it right by one place, each filling the vacated bit with 0. A=11001001 gives 10010010 and 01100100.
- R11: `zero` is 1 exactly when the opcode is defined and the current result is all zeros.
- R12: For opcodes 1, 2, 3, 5, 6 and 7, `carry` is the adder carry-out: increment from all ones gives 1, decrement from zero gives 0, and a subtract with no borrow gives 1. For every other opcode, `carry` is 0.
- R13: Opcodes 14 and 15 are undefined and write no register, even when the control condition is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | $clog2(NREG) | Operand A register select |
| sel_b | input | $clog2(NREG) | Operand B register select |
| dst_en | input | NREG | Per-register load enable (destination code) |
| opcode | input | 4 | Microoperation code |
| sub_mode | input | 1 | Add/subtract mode bit for opcode 2 |
| cv_a | input | 1 | Control variable, first term |
| cv_b | input | 1 | Control variable, second term |
| ext_data | input | W | External word loaded by opcode 13 |
| reg_q | output | NREG*W | Register contents, register i at bits [i*W +: W] |
| zero | output | 1 | Result-is-zero status |
| carry | output | 1 | Adder carry-out status |

## Verification
The two logic operand words and the shift operand from the requirements are applied directly. These exact values catch an operation swapped for another one, and a shift that fills with the wrong bit. Increment from all ones, decrement from zero, negate of zero and subtract with equal operands probe the adder's carry and the zero flag at their wrap points. Both control variables are toggled one at a time, together with undefined opcodes, to tell an inhibited write from a performed one. A long random run with multi-register destinations and equal source selects then compares every register and both flags against a behavioural model on every cycle.

// File: rtl/rt_datapath.sv
module rt_datapath #(
  parameter int W    = 8,
  parameter int NREG = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [$clog2(NREG)-1:0] sel_a,
  input  logic [$clog2(NREG)-1:0] sel_b,
  input  logic [NREG-1:0]       dst_en,
  input  logic [3:0]            opcode,
  input  logic                  sub_mode,
  input  logic                  cv_a,
  input  logic                  cv_b,
  input  logic [W-1:0]          ext_data,
  output logic [NREG*W-1:0]     reg_q,
  output logic                  zero,
  output logic                  carry
);
  localparam logic [3:0] OP_PASS = 4'd0,  OP_ADD = 4'd1,  OP_ADSB = 4'd2,  OP_RSUB = 4'd3;
  localparam logic [3:0] OP_NOT  = 4'd4,  OP_NEG = 4'd5,  OP_INC  = 4'd6,  OP_DEC  = 4'd7;
  localparam logic [3:0] OP_OR   = 4'd8,  OP_AND = 4'd9,  OP_XOR  = 4'd10, OP_SHL  = 4'd11;
  localparam logic [3:0] OP_SHR  = 4'd12, OP_LDX = 4'd13;

  logic [W-1:0] r [NREG];
  logic [W-1:0] bus_a, bus_b;
  logic [W-1:0] ax, ay, res;
  logic         acin, arith, op_ok, wr;
  logic [W:0]   sum;

  assign bus_a = r[sel_a];
  assign bus_b = r[sel_b];

  always_comb begin
    ax = bus_a; ay = bus_b; acin = 1'b0; arith = 1'b1;
    case (opcode)
      OP_ADD:  ;
      OP_ADSB: begin ay = sub_mode ? ~bus_b : bus_b; acin = sub_mode; end
      OP_RSUB: begin ax = bus_b; ay = ~bus_a; acin = 1'b1; end
      OP_NEG:  begin ax = '0; ay = ~bus_a; acin = 1'b1; end
      OP_INC:  begin ay = '0; acin = 1'b1; end
      OP_DEC:  ay = '1;
      default: arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, acin};

  always_comb begin
    op_ok = 1'b1;
    res   = sum[W-1:0];
    case (opcode)
      OP_PASS: res = bus_a;
      OP_NOT:  res = ~bus_a;
      OP_OR:   res = bus_a | bus_b;
      OP_AND:  res = bus_a & bus_b;
      OP_XOR:  res = bus_a ^ bus_b;
      OP_SHL:  res = {bus_a[W-2:0], 1'b0};
      OP_SHR:  res = {1'b0, bus_a[W-1:1]};
      OP_LDX:  res = ext_data;
      OP_ADD, OP_ADSB, OP_RSUB, OP_NEG, OP_INC, OP_DEC: ;
      default: begin op_ok = 1'b0; res = '0; end
    endcase
  end

  assign zero  = op_ok && (res == '0);
  assign carry = arith && sum[W];
  assign wr    = (cv_a | cv_b) & op_ok;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                  r[i] <= '0;
      else if (wr && dst_en[i]) r[i] <= res;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign reg_q[g*W +: W] = r[g];

    // R2: inhibited or unselected registers hold
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!(cv_a || cv_b) || !dst_en[g]) |=> $stable(r[g]));
    // R13: undefined opcodes write nothing
    p_undef_r13: assert property (@(posedge clk) disable iff (rst)
      (opcode >= 4'd14) |=> $stable(r[g]));
    // R3: transfer copies the selected source
    p_xfer_r3: assert property (@(posedge clk) disable iff (rst)
      ((cv_a || cv_b) && dst_en[g] && opcode == OP_PASS) |=> r[g] == $past(bus_a));
    // R10: left shift fills with zero
    p_shl_r10: assert property (@(posedge clk) disable iff (rst)
      ((cv_a || cv_b) && dst_en[g] && opcode == OP_SHL) |=> r[g][0] == 1'b0);
    // R11: a written register is zero exactly when zero was flagged
    p_zero_r11: assert property (@(posedge clk) disable iff (rst)
      ((cv_a || cv_b) && dst_en[g] && opcode <= OP_LDX) |=> (r[g] == '0) == $past(zero));
  end
endmodule

// File: tb/rt_datapath_tb_top.sv
module rt_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, NREG = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] sel_a = '0, sel_b = '0;
  logic [3:0] dst_en = '0, opcode = '0;
  logic sub_mode = 1'b0, cv_a = 1'b0, cv_b = 1'b0;
  logic [7:0] ext_data = '0;
  logic [31:0] reg_q;
  logic zero, carry;

  int checks = 0, errors = 0;
  int m [4];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_datapath #(.W(W), .NREG(NREG)) dut_i (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .dst_en(dst_en),
    .opcode(opcode), .sub_mode(sub_mode), .cv_a(cv_a), .cv_b(cv_b),
    .ext_data(ext_data), .reg_q(reg_q), .zero(zero), .carry(carry));

  function automatic string tag_of(input int op);
    case (op)
      0, 13: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4, 5: return "R7"; 6, 7: return "R8"; 8, 9, 10: return "R9";
      11, 12: return "R10"; default: return "R13";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regs_check(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, int'(reg_q[i*8 +: 8]), m[i]);
  endtask

  task automatic step(input int sa, input int sb, input int dm, input int op,
                      input bit x, input bit ka, input bit kb, input int ext);
    int a, b, s, res, c;
    bit ok, ar;
    sel_a = 2'(sa); sel_b = 2'(sb); dst_en = 4'(dm); opcode = 4'(op);
    sub_mode = x; cv_a = ka; cv_b = kb; ext_data = 8'(ext);
    #1;
    a = m[sa]; b = m[sb]; s = 0; ok = 1; ar = 0; res = 0;
    case (op)
      0: res = a;
      1: begin s = a + b; ar = 1; end
      2: begin s = x ? a + (255 - b) + 1 : a + b; ar = 1; end
      3: begin s = b + (255 - a) + 1; ar = 1; end
      4: res = 255 - a;
      5: begin s = (255 - a) + 1; ar = 1; end
      6: begin s = a + 1; ar = 1; end
      7: begin s = a + 255; ar = 1; end
      8: res = a | b;
      9: res = a & b;
      10: res = a ^ b;
      11: res = (a * 2) % 256;
      12: res = a / 2;
      13: res = ext;
      default: ok = 0;
    endcase
    if (ar) res = s % 256;
    c = ar ? s / 256 : 0;
    chk("R11", int'(zero), (ok && res == 0) ? 1 : 0);
    chk("R12", int'(carry), c);
    @(posedge clk);
    if ((ka || kb) && ok)
      for (int i = 0; i < NREG; i++) if (dm[i]) m[i] = res;
    @(negedge clk);
    regs_check(((ka || kb) && ok) ? tag_of(op) : (ok ? "R2" : "R13"));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) m[i] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regs_check("R1");
    rst = 1'b0;

    step(0, 0, 4'b0010, 13, 0, 1, 0, 8'hAA);
    step(0, 0, 4'b0100, 13, 0, 0, 1, 8'hF0);
    step(1, 2, 4'b0001, 4, 0, 1, 0, 0);  chk("R9", int'(reg_q[7:0]), 8'h55);
    step(1, 2, 4'b0001, 8, 0, 1, 0, 0);  chk("R9", int'(reg_q[7:0]), 8'hFA);
    step(1, 2, 4'b0001, 9, 0, 1, 0, 0);  chk("R9", int'(reg_q[7:0]), 8'hA0);
    step(1, 2, 4'b0001, 10, 0, 1, 0, 0); chk("R9", int'(reg_q[7:0]), 8'h5A);
    step(0, 0, 4'b1000, 13, 0, 1, 0, 8'hC9);
    step(3, 0, 4'b0001, 11, 0, 1, 0, 0); chk("R10", int'(reg_q[7:0]), 8'h92);
    step(3, 0, 4'b0001, 12, 0, 1, 0, 0); chk("R10", int'(reg_q[7:0]), 8'h64);
    // R8: wrap points
    step(0, 0, 4'b0001, 13, 0, 1, 0, 8'hFF);
    step(0, 0, 4'b0001, 6, 0, 1, 0, 0);  chk("R8", int'(reg_q[7:0]), 0);
    step(0, 0, 4'b0001, 7, 0, 1, 0, 0);  chk("R8", int'(reg_q[7:0]), 8'hFF);
    // R2: inhibited write, R13: undefined code with condition true
    step(1, 2, 4'b1111, 1, 0, 0, 0, 0);
    step(1, 2, 4'b1111, 14, 0, 1, 1, 0);
    step(1, 2, 4'b1111, 15, 1, 1, 0, 0);
    // R3: one source into every register
    step(1, 0, 4'b1101, 0, 0, 0, 1, 0);
    // R5/R6: equal operands subtract to zero with no borrow
    step(2, 2, 4'b0010, 2, 1, 1, 0, 0);
    step(2, 2, 4'b0010, 3, 0, 1, 0, 0);
    step(1, 1, 4'b0001, 5, 0, 1, 0, 0);

    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15),
           $urandom_range(0, 15), 1'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 255));

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < NREG; i++) m[i] = 0;
    regs_check("R1");
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule